// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block turns single-word requests from on-chip logic into read and write cycles on an external 16-bit bus that carries first the address and then the data. It drives the address-latch strobe (`ale`), the active-low read and write strobes, and the enable of the bus output drivers, and it registers read data from the bus. A requester raises `req` with an address, write data and a write flag and holds them until `ack` pulses. On `ack` of a read, `rdata` holds the captured word.

The block is clocked at twice the oscillator rate. One clock, called a tick here, is half an oscillator period, so every strobe edge can be placed on a half-period boundary.

A 2-bit timing mode, loaded from bits 7:6 of a configuration byte, selects one of four bus timings. Mode 3 is the standard profile. Mode 0 adds one automatic wait state. Mode 1 starts the strobes early and widens them. Mode 2 does the same and also puts the address out early. An external `ready` input can stretch any strobe in whole-period steps.

The sequencer has five states:
- IDLE: waits for a request.
- ADDR: drives the address and `ale`.
- HOLD: keeps the address on the bus past the fall of `ale`.
- STRB: holds the read or write strobe low.
- RECOV: floats the bus, or keeps write data on it for one tick.

The transitions are:
- IDLE→ADDR when `req` is high.
- ADDR→HOLD and HOLD→STRB when the phase count runs out.
- STRB→STRB, a wait extension, when `ready` is low on the last strobe tick.
- STRB→RECOV when `ready` is high on that tick.
- RECOV→ADDR when the count runs out and `req` is high; RECOV→IDLE when it runs out and `req` is low.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: After reset `ale` is 0, `rd_n` and `wr_n` are 1, `bus_oe` and `ack` are 0, and the timing mode is 3.
- R2: A pulse on `cfg_we` loads the mode from `cfg_byte` bits 7:6, read as a binary mode number 0 to 3; the other bits of `cfg_byte` are ignored.
- R3: Mode 3 timing, counted in ticks from the first tick with `bus_oe` high (tick 0): `ale` is high for 2 ticks and falls at tick 2, the strobe goes low at tick 4 and lasts 2 ticks, and it rises at tick 6.
- R4: Mode 0 timing: `ale` is high for 2 ticks and falls at tick 2, the strobe goes low at tick 4 and lasts 6 ticks, and it rises at tick 10.
- R5: Mode 1 timing: `ale` is high for 1 tick and falls at tick 1, the strobe goes low at tick 2 and lasts 4 ticks, and it rises at tick 6.
- R6: Mode 2 timing: the address is driven one tick before `ale` rises. `ale` is high for 1 tick and falls at tick 2, the strobe goes low at tick 3 and lasts 4 ticks, and it rises at tick 7.
- R7: `ready` is sampled on the last scheduled strobe tick. While it is low there, the strobe is extended by 2 ticks and sampled again. This holds in every mode, including mode 0 on top of its automatic wait.
- R8: Read data is captured on the last strobe tick. `rdata` holds that word from the `ack` tick on.
- R9: During a write, `bus_oe` is high and `bus_out` equals the write data for every tick `wr_n` is low, and for the one tick after `wr_n` rises.
- R10: After a read strobe rises, `bus_oe` stays low for the float interval of the mode before the next address is driven: 2 ticks in modes 3, 0 and 1, and 1 tick in mode 2. `bus_oe` is never high while `rd_n` is low.
- R11: A mode written during a bus cycle does not change that cycle. It applies from the next cycle.
- R12: `ack` is a single-tick pulse on the tick a strobe rises. `rd_n` and `wr_n` are never low together, `ale` is never high while a strobe is low, and each strobe lasts at least 2 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the oscillator rate (one tick = half period) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the timing mode from `cfg_byte` |
| cfg_byte | input | 8 | Configuration byte; bits 7:6 carry the mode |
| req | input | 1 | Bus cycle request, held until `ack` |
| req_we | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-tick completion pulse |
| rdata | output | 16 | Captured read data |
| ready | input | 1 | Low on the last strobe tick stretches the strobe |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Enable for the bus output drivers |
| bus_out | output | 16 | Value driven onto the bus (address or data) |
| bus_in | input | 16 | Value seen on the bus |

## Verification
Each mode is run and measured tick by tick, because a profile swapped between modes still produces strobes that look plausible. A design that placed `ale` wrong or widened the strobe wrong shows up as a shifted fall index or a wrong width.

The bench changes `bus_in` on every strobe tick, so read data taken one tick early or late comes back as the wrong word. `ready` is held low across one and then two samples to catch a design that extends by a single tick or ignores `ready` in mode 0.

Back-to-back reads expose a design that drives the next address before the float interval has passed. A mode written in the middle of a cycle catches a design that re-times a strobe already in progress.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int PH_W = 3;

    typedef enum logic [1:0] {
        BUS_MODE0 = 2'd0,
        BUS_MODE1 = 2'd1,
        BUS_MODE2 = 2'd2,
        BUS_MODE3 = 2'd3
    } bus_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_HOLD  = 3'd2,
        ST_STRB  = 3'd3,
        ST_RECOV = 3'd4
    } bus_state_e;

    // Phase lengths in ticks (half oscillator periods).
    typedef struct packed {
        logic [PH_W-1:0] addr_len;
        logic [PH_W-1:0] hold_len;
        logic [PH_W-1:0] strb_len;
        logic [PH_W-1:0] rec_len;
        logic            ale_late;   // ALE stays low on the first address tick
    } phase_plan_t;

    function automatic phase_plan_t plan_for(bus_mode_e m);
        phase_plan_t p;
        unique case (m)
            BUS_MODE0: p = '{addr_len: 3'd2, hold_len: 3'd2, strb_len: 3'd6, rec_len: 3'd2, ale_late: 1'b0};
            BUS_MODE1: p = '{addr_len: 3'd1, hold_len: 3'd1, strb_len: 3'd4, rec_len: 3'd2, ale_late: 1'b0};
            BUS_MODE2: p = '{addr_len: 3'd2, hold_len: 3'd1, strb_len: 3'd4, rec_len: 3'd1, ale_late: 1'b1};
            default:   p = '{addr_len: 3'd2, hold_len: 3'd2, strb_len: 3'd2, rec_len: 3'd2, ale_late: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/xbus_mode_reg.sv
module xbus_mode_reg
    import xbus_pkg::*;
#(
    parameter int CFG_W    = 8,
    parameter int MODE_LSB = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_byte,
    output bus_mode_e        mode
);
    localparam int MODE_MSB = MODE_LSB + 1;

    bus_mode_e mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= BUS_MODE3;
        end else if (cfg_we) begin
            mode_q <= bus_mode_e'(cfg_byte[MODE_MSB:MODE_LSB]);
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int WAIT_TICKS = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  bus_mode_e mode,
    input  logic      req,
    input  logic      req_we,
    input  logic      ready,
    output logic      start,
    output logic      capture,
    output logic      ack,
    output logic      ale,
    output logic      rd_n,
    output logic      wr_n,
    output logic      drv_addr,
    output logic      drv_data
);
    localparam logic [PH_W-1:0] ONE      = PH_W'(1);
    localparam logic [PH_W-1:0] WAIT_CNT = PH_W'(WAIT_TICKS - 1);

    bus_state_e      state_q, state_d;
    logic [PH_W-1:0] cnt_q, cnt_d;
    bus_mode_e       cur_mode_q;
    logic            we_q;
    logic            ack_q, ack_d;
    phase_plan_t     plan_cur, plan_new;
    logic            cnt_done;

    assign plan_cur = plan_for(cur_mode_q);
    assign plan_new = plan_for(mode);
    assign cnt_done = (cnt_q == '0);

    // Next state and counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_done ? cnt_q : cnt_q - ONE;
        start   = 1'b0;
        capture = 1'b0;
        ack_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    start   = 1'b1;
                    state_d = ST_ADDR;
                    cnt_d   = plan_new.addr_len - ONE;
                end
            end
            ST_ADDR: begin
                if (cnt_done) begin
                    state_d = ST_HOLD;
                    cnt_d   = plan_cur.hold_len - ONE;
                end
            end
            ST_HOLD: begin
                if (cnt_done) begin
                    state_d = ST_STRB;
                    cnt_d   = plan_cur.strb_len - ONE;
                end
            end
            ST_STRB: begin
                if (cnt_done) begin
                    if (!ready) begin
                        cnt_d = WAIT_CNT;
                    end else begin
                        capture = !we_q;
                        ack_d   = 1'b1;
                        state_d = ST_RECOV;
                        cnt_d   = plan_cur.rec_len - ONE;
                    end
                end
            end
            ST_RECOV: begin
                if (cnt_done) begin
                    if (req) begin
                        start   = 1'b1;
                        state_d = ST_ADDR;
                        cnt_d   = plan_new.addr_len - ONE;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            cur_mode_q <= BUS_MODE3;
            we_q       <= 1'b0;
            ack_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ack_q   <= ack_d;
            if (start) begin
                cur_mode_q <= mode;
                we_q       <= req_we;
            end
        end
    end

    // Outputs.
    always_comb begin
        ale      = 1'b0;
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        drv_addr = 1'b0;
        drv_data = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ADDR: begin
                drv_addr = 1'b1;
                ale      = !(plan_cur.ale_late && (cnt_q == plan_cur.addr_len - ONE));
            end
            ST_HOLD: begin
                drv_addr = 1'b1;
            end
            ST_STRB: begin
                rd_n     = we_q;
                wr_n     = !we_q;
                drv_data = we_q;
            end
            ST_RECOV: begin
                drv_data = we_q && (cnt_q == plan_cur.rec_len - ONE);
            end
            default: begin
            end
        endcase
    end

    assign ack = ack_q;

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              capture,
    input  logic              drv_addr,
    input  logic              drv_data,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) begin
                rdata_q <= bus_in;
            end
        end
    end

    assign bus_out = drv_addr ? addr_q : wdata_q;
    assign bus_oe  = drv_addr | drv_data;
    assign rdata   = rdata_q;

endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
    import xbus_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CFG_W      = 8,
    parameter int MODE_LSB   = 6,
    parameter int WAIT_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_byte,
    input  logic              req,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    input  logic              ready,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_out,
    input  logic [DATA_W-1:0] bus_in
);
    bus_mode_e mode;
    logic      start, capture, drv_addr, drv_data;

    xbus_mode_reg #(
        .CFG_W    (CFG_W),
        .MODE_LSB (MODE_LSB)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_byte (cfg_byte),
        .mode     (mode)
    );

    xbus_seq #(
        .WAIT_TICKS (WAIT_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .req      (req),
        .req_we   (req_we),
        .ready    (ready),
        .start    (start),
        .capture  (capture),
        .ack      (ack),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .drv_addr (drv_addr),
        .drv_data (drv_data)
    );

    xbus_datapath #(
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .capture   (capture),
        .drv_addr  (drv_addr),
        .drv_data  (drv_data),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (bus_in),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .rdata     (rdata)
    );

endmodule

// File: rtl/xbus_cycle_ctrl_chk.sv
module xbus_cycle_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic bus_oe,
    input logic ack
);
    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_ale_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && bus_oe));

    assert_ack_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ($rose(rd_n) || $rose(wr_n)));

    assert_rd_min_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |=> !rd_n);

    assert_wr_min_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |=> !wr_n);

    assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);

    assert_write_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> bus_oe);

    assert_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> bus_oe);
endmodule

bind xbus_cycle_ctrl xbus_cycle_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .bus_oe (bus_oe),
    .ack    (ack)
);

// File: tb/test_xbus_cycle_ctrl.sv
module test_xbus_cycle_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_byte = '0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic        ready = 1'b1;
    logic        ale, rd_n, wr_n, bus_oe;
    logic [15:0] bus_out;
    logic [15:0] bus_in = '0;

    int n_total = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    xbus_cycle_ctrl i_xbus_cycle_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_byte  (cfg_byte),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ack       (ack),
        .rdata     (rdata),
        .ready     (ready),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .bus_oe    (bus_oe),
        .bus_out   (bus_out),
        .bus_in    (bus_in)
    );

    // Expected timing per mode: ALE fall index, ALE width, strobe start, strobe width, float.
    function automatic int exp_alef(int m);  return (m == 1) ? 1 : 2; endfunction
    function automatic int exp_alew(int m);  return (m == 1 || m == 2) ? 1 : 2; endfunction
    function automatic int exp_strt(int m);  return (m == 1) ? 2 : (m == 2) ? 3 : 4; endfunction
    function automatic int exp_strw(int m);  return (m == 0) ? 6 : (m == 3) ? 2 : 4; endfunction
    function automatic int exp_float(int m); return (m == 2) ? 1 : 2; endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic set_mode(input int m);
        @(negedge clk);
        cfg_byte = {m[1:0], 6'b101101};
        cfg_we   = 1'b1;
        @(negedge clk);
        cfg_we   = 1'b0;
        cfg_byte = 8'hFF;
    endtask

    // Runs one cycle and measures it in ticks from the first tick with bus_oe high.
    task automatic do_cycle(input logic we, input logic [15:0] a, input logic [15:0] wd,
                            input int hold_h, output int t_alef, output int ale_w,
                            output int t_strb, output int strb_w, output logic [15:0] rd_val,
                            output bit wr_ok, output bit done);
        int  t;
        bit  prev_ale;
        bit  stb;
        t = -1; t_alef = -1; ale_w = 0; t_strb = -1; strb_w = 0;
        rd_val = '0; wr_ok = 1'b1; done = 1'b0; prev_ale = 1'b0;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        ready = (hold_h == 0);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (t < 0 && bus_oe) t = 0;
            else if (t >= 0) t++;
            if (t >= 0) begin
                if (ale) ale_w++;
                if (prev_ale && !ale && t_alef < 0) t_alef = t;
                prev_ale = ale;
                stb = we ? !wr_n : !rd_n;
                if (stb) begin
                    if (t_strb < 0) t_strb = t;
                    strb_w++;
                    if (we && !(bus_oe && bus_out == wd)) wr_ok = 1'b0;
                    bus_in = a ^ 16'(strb_w);
                    ready  = (strb_w >= hold_h);
                end
                if (ack) begin
                    rd_val = rdata;
                    if (we && !(bus_oe && bus_out == wd)) wr_ok = 1'b0;
                    req  = 1'b0;
                    done = 1'b1;
                    break;
                end
            end
        end
        req = 1'b0;
        ready = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset();
        check(ale == 0, "R1 ale", int'(ale), 0);
        check(rd_n == 1 && wr_n == 1, "R1 strobes", int'({rd_n, wr_n}), 3);
        check(bus_oe == 0, "R1 bus_oe", int'(bus_oe), 0);
        check(ack == 0, "R1 ack", int'(ack), 0);
    endtask

    task automatic test_read_mode(input int m, input string tag, input logic [15:0] a);
        int t_alef, ale_w, t_strb, strb_w;
        logic [15:0] rv;
        bit wok, done;
        do_cycle(1'b0, a, 16'h0, 0, t_alef, ale_w, t_strb, strb_w, rv, wok, done);
        check(done, {tag, " ack"}, int'(done), 1);
        check(t_alef == exp_alef(m), {tag, " ale fall"}, t_alef, exp_alef(m));
        check(ale_w == exp_alew(m), {tag, " ale width"}, ale_w, exp_alew(m));
        check(t_strb == exp_strt(m), {tag, " rd start"}, t_strb, exp_strt(m));
        check(strb_w == exp_strw(m), {tag, " rd width"}, strb_w, exp_strw(m));
        // R8: last strobe tick carries a ^ width
        check(rv == (a ^ 16'(exp_strw(m))), "R8 capture", int'(rv), int'(a ^ 16'(exp_strw(m))));
    endtask

    task automatic test_ready(input int m, input int hold_h, input int exp_w);
        int t_alef, ale_w, t_strb, strb_w;
        logic [15:0] rv;
        bit wok, done;
        set_mode(m);
        do_cycle(1'b0, 16'h3C5A, 16'h0, hold_h, t_alef, ale_w, t_strb, strb_w, rv, wok, done);
        check(strb_w == exp_w, "R7 ready stretch width", strb_w, exp_w);
        check(rv == (16'h3C5A ^ 16'(exp_w)), "R8 capture after wait", int'(rv), int'(16'h3C5A ^ 16'(exp_w)));
    endtask

    task automatic test_write(input int m);
        int t_alef, ale_w, t_strb, strb_w;
        logic [15:0] rv;
        bit wok, done;
        set_mode(m);
        do_cycle(1'b1, 16'h1234, 16'hBEEF, 0, t_alef, ale_w, t_strb, strb_w, rv, wok, done);
        check(done, "R9 write ack", int'(done), 1);
        check(strb_w == exp_strw(m), "R9 wr width", strb_w, exp_strw(m));
        check(t_strb == exp_strt(m), "R9 wr start", t_strb, exp_strt(m));
        check(wok, "R9 write data held", int'(wok), 1);
    endtask

    task automatic test_back_to_back(input int m);
        int gap;
        bit addr_ok;
        set_mode(m);
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 16'hA001;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ack) break;
        end
        req_addr = 16'hA002;
        gap = 0;
        addr_ok = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (bus_oe) begin
                addr_ok = (bus_out == 16'hA002);
                break;
            end
            gap++;
            @(negedge clk);
        end
        check(gap == exp_float(m), "R10 float interval", gap, exp_float(m));
        check(addr_ok, "R10 next address", int'(bus_out), 16'hA002);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ack) break;
        end
        req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_mid_change();
        int t_alef, ale_w, t_strb, strb_w;
        logic [15:0] rv;
        bit wok, done;
        set_mode(3);
        fork
            do_cycle(1'b0, 16'h0F0F, 16'h0, 0, t_alef, ale_w, t_strb, strb_w, rv, wok, done);
            begin
                repeat (3) @(negedge clk);
                cfg_byte = {2'd1, 6'b010010};
                cfg_we   = 1'b1;
                @(negedge clk);
                cfg_we   = 1'b0;
            end
        join
        check(strb_w == 2, "R11 current cycle unchanged", strb_w, 2);
        do_cycle(1'b0, 16'h0F0F, 16'h0, 0, t_alef, ale_w, t_strb, strb_w, rv, wok, done);
        check(strb_w == 4, "R11 next cycle uses new mode", strb_w, 4);
        check(t_alef == 1, "R11 next cycle ale", t_alef, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        // R1: default mode 3 without any configuration write
        test_read_mode(3, "R1 R3 mode3", 16'h5A01);
        set_mode(0);
        test_read_mode(0, "R2 R4 mode0", 16'h5A02);
        set_mode(1);
        test_read_mode(1, "R2 R5 mode1", 16'h5A03);
        set_mode(2);
        test_read_mode(2, "R2 R6 mode2", 16'h5A04);
        set_mode(3);
        test_read_mode(3, "R2 R3 mode3 again", 16'h5A05);
        test_ready(3, 3, 4);
        test_ready(3, 5, 6);
        test_ready(0, 7, 8);
        test_ready(2, 5, 6);
        test_write(3);
        test_write(1);
        test_write(2);
        test_back_to_back(3);
        test_back_to_back(2);
        test_back_to_back(0);
        test_mid_change();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule